// File: doc/BRIEF.md
# Registered Slot Interconnect Switch

This block joins the component slots of a reconfigurable system with point-to-point streaming channels. Each of its four output ports follows one input port of its choice, or none at all, and several outputs may follow the same input. The routes are set only by an external controller through a small command port. A connect command names a source and a destination. A disconnect command names only a destination. Each command is answered with a one-cycle acknowledge pulse. What the data carries never changes a route.

Both the forward data and the backward stall signal pass through a fixed number of register stages. Timing therefore does not depend on how far apart two slots sit on the die. Switches can be chained into a larger hierarchy: each level adds the same fixed latency, and a chain still accepts one beat on every cycle. When an output that is already in use is moved to a new source, the switch holds that output idle for one beat first. A sink therefore never sees beats from two sources glued together.

Top module: `xbar_slot_switch`

## Requirements
- R1: Once output d is connected to input s (any s, including d itself, and several outputs may share one s), out_data/out_valid of port d reproduce in_data/in_valid of port s.
- R2: The data path latency is exactly STAGES cycles (default 2). A new beat can enter on every cycle, with no bubbles, while the route stays unchanged.
- R3: An output with no route drives out_valid low and out_data zero for every beat that enters after the disconnect takes effect. Whenever out_valid is low, out_data is zero.
- R4: Command encoding: cmd_op = 1 means connect(cmd_src, cmd_dst), cmd_op = 0 means disconnect(cmd_dst). On a disconnect, cmd_src has no effect.
- R5: cmd_ack is a one-cycle pulse. It comes one cycle after a disconnect, or after a connect to an unrouted output. It comes two cycles after a connect to an output that is already routed.
- R6: A connect to an output that is already routed leaves that output unrouted for exactly one beat before the new source takes over.
- R7: out_stall[d] appears on in_stall[s] STAGES cycles later, for the source s that output d currently selects. Stalls from outputs that share a source are ORed. A source that no output selects sees no stall.
- R8: After reset no route exists, every out_valid, out_data, in_stall and cmd_ack is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | NPORT*DW | Source data, port p in bits p*DW+:DW |
| in_valid | input | NPORT | Source beat valid, one bit per port |
| in_stall | output | NPORT | Stall returned to each source |
| out_data | output | NPORT*DW | Sink data, port p in bits p*DW+:DW |
| out_valid | output | NPORT | Sink beat valid |
| out_stall | input | NPORT | Stall raised by each sink |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 1 | 1 = connect, 0 = disconnect |
| cmd_src | input | SW | Source port of a connect |
| cmd_dst | input | SW | Destination (output) port |
| cmd_ack | output | 1 | Command done pulse |

## Verification
The hardest case to reach is moving an output that is busy while beats from the old source are still in the pipeline. The old beats must drain, one idle beat must follow, and the new source must take over, all without a beat being lost or duplicated. The stimulus reaches this case with connects to outputs that are already routed, including a fan-out of one source onto a busy output. Random valid and stall patterns run throughout. A bench model of the routes then predicts every beat on every output, the stall seen by every source, and the exact acknowledge cycle.

// File: rtl/xbar_pkg.sv
// Shared types and encodings of the slot switch.
// Assumes: a single clock domain for all users of these definitions.
package xbar_pkg;
    // Command operation codes on cmd_op.
    localparam logic OP_DISC = 1'b0;
    localparam logic OP_CONN = 1'b1;

    // Route controller states: idle, or one idle beat before a replacement.
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_GAP  = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/xbar_route_ctrl.sv
// Route table and command sequencer of the slot switch.
// Holds one route (valid flag plus source index) per output. Connect to an
// unrouted output or disconnect: applied next edge, acknowledged then.
// Connect to a routed output: route dropped for one cycle, then the new source
// set and acknowledged. Assumes: the controller waits for cmd_ack before it
// sends the next command; a command sent during the gap cycle is dropped.
module xbar_route_ctrl
    import xbar_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int SW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_op,
    input  logic [SW-1:0]         cmd_src,
    input  logic [SW-1:0]         cmd_dst,
    output logic [NPORT-1:0]      route_v,
    output logic [NPORT*SW-1:0]   route_src,
    output logic                  cmd_ack
);
    ctl_state_t    state;
    logic [SW-1:0] gap_src;
    logic [SW-1:0] gap_dst;

    // Command sequencing and route table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CTL_IDLE;
            route_v   <= '0;
            route_src <= '0;
            gap_src   <= '0;
            gap_dst   <= '0;
            cmd_ack   <= 1'b0;
        end else begin
            cmd_ack <= 1'b0;
            case (state)
                CTL_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_op == OP_CONN && route_v[cmd_dst]) begin
                            route_v[cmd_dst] <= 1'b0;
                            gap_src          <= cmd_src;
                            gap_dst          <= cmd_dst;
                            state            <= CTL_GAP;
                        end else begin
                            route_v[cmd_dst] <= cmd_op;
                            if (cmd_op == OP_CONN) begin
                                route_src[cmd_dst*SW +: SW] <= cmd_src;
                            end
                            cmd_ack <= 1'b1;
                        end
                    end
                end
                CTL_GAP: begin
                    route_v[gap_dst]            <= 1'b1;
                    route_src[gap_dst*SW +: SW] <= gap_src;
                    cmd_ack                     <= 1'b1;
                    state                       <= CTL_IDLE;
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> ($past(cmd_valid) || $past(state == CTL_GAP))); // R5
    AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_GAP) |=> (state == CTL_IDLE)); // R6

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_chk
            AST_REPLACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                (route_v[g] && $past(route_v[g]))
                |-> (route_src[g*SW +: SW] == $past(route_src[g*SW +: SW]))); // R6
        end
    endgenerate
endmodule

// File: rtl/xbar_lane.sv
// Forward data lane for one output port.
// Selects one source through a mux gated by the route valid flag, then passes
// the beat through STAGES registers. Data is forced to zero whenever the beat
// is not valid. Assumes STAGES >= 1.
module xbar_lane #(
    parameter int NPORT  = 4,
    parameter int DW     = 8,
    parameter int SW     = 2,
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT*DW-1:0]   in_data,
    input  logic [NPORT-1:0]      in_valid,
    input  logic                  sel_v,
    input  logic [SW-1:0]         sel_src,
    output logic [DW-1:0]         out_d,
    output logic                  out_v
);
    logic [DW-1:0]     mux_d;
    logic              mux_v;
    logic [DW-1:0]     pd [STAGES];
    logic [STAGES-1:0] pv;

    // Source selection with zero fill for idle beats.
    always_comb begin
        mux_v = sel_v && in_valid[sel_src];
        mux_d = mux_v ? in_data[sel_src*DW +: DW] : '0;
    end

    genvar st;
    generate
        for (st = 0; st < STAGES; st++) begin : g_stage
            // One register stage of the lane.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pd[st] <= '0;
                    pv[st] <= 1'b0;
                end else if (st == 0) begin
                    pd[st] <= mux_d;
                    pv[st] <= mux_v;
                end else begin
                    pd[st] <= pd[(st == 0) ? 0 : st-1];
                    pv[st] <= pv[(st == 0) ? 0 : st-1];
                end
            end
        end
    endgenerate

    assign out_d = pd[STAGES-1];
    assign out_v = pv[STAGES-1];

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_v |-> (out_d == '0)); // R3
    AST_UNROUTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_v |=> !pv[0]); // R3
endmodule

// File: rtl/xbar_stall_ret.sv
// Backward stall path of the slot switch.
// Delays each sink stall by STAGES registers, then steers it to the source
// that the sink's output currently selects; stalls sharing a source are ORed.
// Assumes STAGES >= 1.
module xbar_stall_ret #(
    parameter int NPORT  = 4,
    parameter int SW     = 2,
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      out_stall,
    input  logic [NPORT-1:0]      route_v,
    input  logic [NPORT*SW-1:0]   route_src,
    output logic [NPORT-1:0]      in_stall
);
    logic [NPORT-1:0] sp [STAGES];

    genvar st;
    generate
        for (st = 0; st < STAGES; st++) begin : g_stage
            // One register stage of the stall return.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sp[st] <= '0;
                end else if (st == 0) begin
                    sp[st] <= out_stall;
                end else begin
                    sp[st] <= sp[(st == 0) ? 0 : st-1];
                end
            end
        end
    endgenerate

    // Steer delayed stalls to the selected sources.
    always_comb begin
        in_stall = '0;
        for (int s = 0; s < NPORT; s++) begin
            for (int d = 0; d < NPORT; d++) begin
                if (route_v[d] && route_src[d*SW +: SW] == s[SW-1:0]
                    && sp[STAGES-1][d]) begin
                    in_stall[s] = 1'b1;
                end
            end
        end
    end

    AST_STALL_NOROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(route_v) == 0) |-> (in_stall == '0)); // R7
endmodule

// File: rtl/xbar_slot_switch.sv
// Four-port registered slot interconnect switch (port count is a parameter).
// Each output follows one input chosen by the route controller, or none.
// Data and stall both cross STAGES registers. Assumes one clock domain and a
// controller that waits for cmd_ack between commands.
module xbar_slot_switch
    import xbar_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2,
    localparam int SW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT*DW-1:0]   in_data,
    input  logic [NPORT-1:0]      in_valid,
    output logic [NPORT-1:0]      in_stall,
    output logic [NPORT*DW-1:0]   out_data,
    output logic [NPORT-1:0]      out_valid,
    input  logic [NPORT-1:0]      out_stall,
    input  logic                  cmd_valid,
    input  logic                  cmd_op,
    input  logic [SW-1:0]         cmd_src,
    input  logic [SW-1:0]         cmd_dst,
    output logic                  cmd_ack
);
    logic [NPORT-1:0]    route_v;
    logic [NPORT*SW-1:0] route_src;

    xbar_route_ctrl #(.NPORT(NPORT), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_src   (cmd_src),
        .cmd_dst   (cmd_dst),
        .route_v   (route_v),
        .route_src (route_src),
        .cmd_ack   (cmd_ack)
    );

    genvar d;
    generate
        for (d = 0; d < NPORT; d++) begin : g_lane
            xbar_lane #(.NPORT(NPORT), .DW(DW), .SW(SW), .STAGES(STAGES)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_data  (in_data),
                .in_valid (in_valid),
                .sel_v    (route_v[d]),
                .sel_src  (route_src[d*SW +: SW]),
                .out_d    (out_data[d*DW +: DW]),
                .out_v    (out_valid[d])
            );
        end
    endgenerate

    xbar_stall_ret #(.NPORT(NPORT), .SW(SW), .STAGES(STAGES)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_stall (out_stall),
        .route_v   (route_v),
        .route_src (route_src),
        .in_stall  (in_stall)
    );
endmodule

// File: tb/xbar_slot_switch_test.sv
// Scoreboard bench: the driver pushes predicted output beats into a queue and
// the monitor pops them STAGES cycles later. Routes are modelled per cycle.
module xbar_slot_switch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int ST = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*DW-1:0]  in_data = '0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP-1:0]     in_stall;
    logic [NP*DW-1:0]  out_data;
    logic [NP-1:0]     out_valid;
    logic [NP-1:0]     out_stall = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_op = 1'b0;
    logic [1:0]        cmd_src = '0;
    logic [1:0]        cmd_dst = '0;
    logic              cmd_ack;

    xbar_slot_switch #(.NPORT(NP), .DW(DW), .STAGES(ST)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_stall(in_stall),
        .out_data(out_data), .out_valid(out_valid), .out_stall(out_stall),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_ack(cmd_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ack_at = -1;

    // Route model as seen by the switch during the current cycle.
    logic       m_v   [NP];
    logic [1:0] m_src [NP];
    logic       gap_now [NP];
    int         sch_at  [NP][2];
    logic       sch_v   [NP][2];
    logic [1:0] sch_src [NP][2];
    logic       sch_gap [NP][2];

    typedef struct packed {
        logic [NP*DW-1:0] d;
        logic [NP-1:0]    v;
        logic [NP*4-1:0]  tag;
    } exp_t;
    exp_t eq[$];
    logic [NP-1:0] st_hist0 = '0;
    logic [NP-1:0] st_hist1 = '0;

    logic       want_cmd = 1'b0;
    logic       want_op;
    logic [1:0] want_src;
    logic [1:0] want_dst;
    int         vmode = 0;

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s cyc=%0d actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    // One clock cycle: monitor, then drive and predict.
    task automatic cycle();
        exp_t e;
        logic [NP-1:0] exp_st;
        @(negedge clk);
        cyc++;
        for (int d = 0; d < NP; d++) begin
            gap_now[d] = 1'b0;
            for (int j = 0; j < 2; j++) begin
                if (sch_at[d][j] == cyc) begin
                    m_v[d]     = sch_v[d][j];
                    m_src[d]   = sch_src[d][j];
                    gap_now[d] = sch_gap[d][j];
                    sch_at[d][j] = -1;
                end
            end
        end
        // Monitor: beats entered STAGES cycles ago (R1, R2, R3, R6, R8 tags).
        if (eq.size() >= ST) begin
            e = eq.pop_front();
            for (int d = 0; d < NP; d++) begin
                check(out_valid[d] == e.v[d], int'(e.tag[d*4 +: 4]), $sformatf("valid out%0d", d),
                      32'(out_valid[d]), 32'(e.v[d]));
                check(out_data[d*DW +: DW] == e.d[d*DW +: DW], int'(e.tag[d*4 +: 4]),
                      $sformatf("data out%0d", d), 32'(out_data[d*DW +: DW]), 32'(e.d[d*DW +: DW]));
            end
        end
        // R5: acknowledge exactly in its cycle.
        check(cmd_ack == (ack_at == cyc), 5, "cmd_ack", 32'(cmd_ack), 32'(ack_at == cyc));
        // R7: stall from two cycles ago steered by the current routes.
        exp_st = '0;
        for (int d = 0; d < NP; d++)
            if (m_v[d] && st_hist1[d]) exp_st[m_src[d]] = 1'b1;
        check(in_stall == exp_st, 7, "in_stall", 32'(in_stall), 32'(exp_st));
        // Driver: new inputs and command.
        in_data = $urandom;
        case (vmode)
            0: in_valid = 4'($urandom);
            1: in_valid = '1;
            default: in_valid = '0;
        endcase
        out_stall = 4'($urandom);
        cmd_valid = 1'b0;
        if (want_cmd) begin
            cmd_valid = 1'b1;
            cmd_op    = want_op;
            cmd_src   = want_src;
            cmd_dst   = want_dst;
            want_cmd  = 1'b0;
            if (!want_op) begin
                // R4: disconnect ignores cmd_src (driven random by caller).
                sch_at[want_dst][0] = cyc + 1; sch_v[want_dst][0] = 1'b0;
                sch_src[want_dst][0] = 2'd0; sch_gap[want_dst][0] = 1'b0;
                ack_at = cyc + 1;
            end else if (m_v[want_dst]) begin
                // R6: one idle beat, then the new source.
                sch_at[want_dst][0] = cyc + 1; sch_v[want_dst][0] = 1'b0;
                sch_src[want_dst][0] = 2'd0; sch_gap[want_dst][0] = 1'b1;
                sch_at[want_dst][1] = cyc + 2; sch_v[want_dst][1] = 1'b1;
                sch_src[want_dst][1] = want_src; sch_gap[want_dst][1] = 1'b0;
                ack_at = cyc + 2;
            end else begin
                sch_at[want_dst][0] = cyc + 1; sch_v[want_dst][0] = 1'b1;
                sch_src[want_dst][0] = want_src; sch_gap[want_dst][0] = 1'b0;
                ack_at = cyc + 1;
            end
        end
        for (int d = 0; d < NP; d++) begin
            e.v[d] = m_v[d] && in_valid[m_src[d]];
            e.d[d*DW +: DW] = e.v[d] ? in_data[m_src[d]*DW +: DW] : '0;
            e.tag[d*4 +: 4] = gap_now[d] ? 4'd6 : (m_v[d] ? 4'd1 : 4'd3);
        end
        eq.push_back(e);
        st_hist1 = st_hist0;
        st_hist0 = out_stall;
    endtask

    task automatic do_cmd(input logic op, input logic [1:0] src,
                          input logic [1:0] dst, input int extra);
        want_op = op; want_src = src; want_dst = dst; want_cmd = 1'b1;
        cycle();
        while (cyc < ack_at) cycle();
        repeat (extra) cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_t z;
        for (int d = 0; d < NP; d++) begin
            m_v[d] = 1'b0; m_src[d] = '0; gap_now[d] = 1'b0;
            for (int j = 0; j < 2; j++) begin
                sch_at[d][j] = -1; sch_v[d][j] = 1'b0;
                sch_src[d][j] = '0; sch_gap[d][j] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        // R8: reset state at the ports.
        check(out_valid == '0, 8, "reset out_valid", 32'(out_valid), 0);
        check(out_data == '0, 8, "reset out_data", out_data, 0);
        check(in_stall == '0, 8, "reset in_stall", 32'(in_stall), 0);
        check(cmd_ack == 1'b0, 8, "reset cmd_ack", 32'(cmd_ack), 0);
        rst_n = 1'b1;
        z.d = '0; z.v = '0; z.tag = {NP{4'd8}};
        eq.push_back(z); eq.push_back(z);
        // R3: nothing routed, random traffic stays invisible.
        repeat (6) cycle();
        // R1: a full permutation including a self route.
        do_cmd(1'b1, 2'd0, 2'd1, 0);
        do_cmd(1'b1, 2'd2, 2'd0, 0);
        do_cmd(1'b1, 2'd3, 2'd3, 0);
        do_cmd(1'b1, 2'd1, 2'd2, 20);
        // R2: all-valid stream, every beat must come through.
        vmode = 1;
        repeat (15) cycle();
        // R6: fan-out of source 0 onto busy output 3 during a full stream.
        do_cmd(1'b1, 2'd0, 2'd3, 10);
        // R6: reconnect to the same source still takes the gap.
        do_cmd(1'b1, 2'd0, 2'd3, 6);
        // R4: disconnect with a junk source field.
        do_cmd(1'b0, 2'd2, 2'd1, 8);
        vmode = 0;
        do_cmd(1'b0, 2'd1, 2'd1, 4);
        do_cmd(1'b1, 2'd3, 2'd1, 8);
        // Random command mix under random traffic (R1, R5, R6, R7).
        for (int k = 0; k < 60; k++) begin
            vmode = (k % 5 == 0) ? 1 : 0;
            do_cmd(1'($urandom), 2'($urandom), 2'($urandom), int'($urandom % 4));
        end
        // R3: clear every route, then idle inputs.
        for (int d = 0; d < NP; d++) do_cmd(1'b0, 2'($urandom), 2'(d), 0);
        vmode = 2;
        repeat (8) cycle();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule